// File: doc/BRIEF.md
# SPI Master Channel with Register Bank

This block is one SPI master channel run entirely through a small set of memory-mapped registers. Software, or a DMA engine outside the block, writes a configuration word and a control word, feeds transmit words into a one-word holding register, and collects received words from a receive register. The channel produces the serial clock, the outgoing data line and a chip-select line, and samples the incoming data line.

The configuration word selects the clock polarity and phase and the chip-select polarity. It also sets the bit rate as a power-of-two division, the word length from 4 to 32 bits, and one of three directions: both ways, receive only, or send only. Two request outputs tell an external DMA engine when the transmit register can take a word and when a received word is waiting.

Chip-select is not tied to the channel enable. It is asserted only while a hold bit in the configuration is set, so one select period can span many words.

Top module: `spi_chan`

## Requirements
- R1: Register byte offsets are: configuration 0x00, status 0x04, control 0x08, transmit 0x0C, receive 0x10. Configuration bits are: 0 phase, 1 polarity, 5:2 rate exponent E, 6 select polarity, 11:7 word length minus one, 13:12 direction, 14 transmit request enable, 15 receive request enable, 20 select hold. Reading the configuration returns these fields and zero in every other bit.
- R2: Status bit 0 is receive-full, bit 1 is transmit-empty and bit 2 is end-of-transfer. After reset the status reads 0x6, and the configuration and control read 0.
- R3: The serial clock idles at the polarity bit. With phase 0 the incoming line is sampled on the leading edge and the outgoing line changes on the trailing edge. With phase 1 the outgoing line changes on the leading edge and sampling is on the trailing edge. Words are sent MSB first.
- R4: Each serial clock half-period lasts 2^E system clocks, so the bit rate is the reference rate (half the system clock) shifted right by E. A word of W bits gives exactly 2W clock edges.
- R5: The word length W is field+1. Field values below 3 act as 3, giving 4 bits. Only the low W bits of a transmit word are sent. A received word is right-aligned, with zeros above bit W-1.
- R6: Direction 00 is full duplex and 01 is receive only. Direction 10 is send only, and there receive-full never sets.
- R7: In receive-only mode, one write to the transmit register starts clocking. Further words then start on their own while the channel stays enabled, each one once the previous word has been read out of the receive register.
- R8: Control bit 0 enables the channel. Words are only shifted while it is set. Clearing it stops shifting and discards any unread received word.
- R9: The select output is asserted only while the hold bit is set, whatever the enable. Its active level is low when bit 6 is 1 and high when bit 6 is 0.
- R10: Writing the transmit register clears transmit-empty. It sets again when the word moves into the shifter. A second word written during a transfer goes out directly after the first.
- R11: Receive-full sets when a word completes and clears when the receive register is read. End-of-transfer is set exactly when the shifter is idle and no transmit word is waiting.
- R12: The transmit request is high while transmit-empty and bit 14 are both set. The receive request is high while receive-full and bit 15 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rd | input | 1 | Register read strobe (side effects on receive register) |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_out | output | 1 | Chip-select |
| dma_tx_req | output | 1 | Transmit register may be written |
| dma_rx_req | output | 1 | Received word waiting |

## Verification
A wrong bit or half-period counter shows up at once at the pins. The clock edge count for the word is off, the spacing between edges changes, or the word a slave model collects is shifted. This is visible within the one word where the fault sits. A stale receive-full flag shows at the next status read, because of the flag coupling to the DMA request and, in receive-only mode, to the stall of the next word. An unpurged flag after disable shows in the first status read with the channel off. The select line is compared against its model on every clock, so a wrong polarity or a wrong coupling to the enable is caught within one cycle.

// File: rtl/spi_chan.sv
module spi_chan #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_out,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  localparam int DW = 32;
  localparam int EW = 4;
  localparam int LW = 5;
  localparam int CW = (1 << EW) - 1;
  localparam int HW = LW + 1;
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(16);
  localparam logic [1:0] M_RXO = 2'b01;
  localparam logic [1:0] M_TXO = 2'b10;

  logic          cpha, cpol, cs_low, dreq_w, dreq_r, hold;
  logic [EW-1:0] dexp;
  logic [LW-1:0] wl;
  logic [1:0]    mode;
  logic          en, busy, armed, tx_full, rx_full, smp;
  logic [DW-1:0] txbuf, rxbuf, shreg;
  logic [HW-1:0] half;
  logic [CW-1:0] cnt;

  logic [LW-1:0] wlen;
  logic [CW-1:0] lim;
  logic          half_end, last_half, word_done, rx_only, load_tx, load_cont, rd_rx;
  logic [DW-1:0] rx_word, cfg_word;

  assign wlen      = (wl < LW'(3)) ? LW'(3) : wl;
  assign lim       = (CW'(1) << dexp) - CW'(1);
  assign half_end  = busy && (cnt == lim);
  assign last_half = (half == {wlen, 1'b1});
  assign word_done = half_end && last_half;
  assign rx_only   = (mode == M_RXO);
  assign load_tx   = en && !busy && tx_full;
  assign load_cont = en && !busy && !tx_full && armed && rx_only && !rx_full;
  assign rd_rx     = bus_rd && (bus_addr == A_RX);
  assign rx_word   = {shreg[DW-2:0], smp} & ({DW{1'b1}} >> (LW'(DW-1) - wlen));

  assign sclk       = busy ? (cpol ^ cpha ^ half[0]) : cpol;
  assign mosi       = busy & shreg[wlen];
  assign cs_out     = hold ^ cs_low;
  assign dma_tx_req = !tx_full && dreq_w;
  assign dma_rx_req = rx_full && dreq_r;

  assign cfg_word = {11'b0, hold, 4'b0, dreq_r, dreq_w, mode, wl, cs_low, dexp, cpol, cpha};

  always_comb begin
    case (bus_addr)
      A_CFG:   bus_rdata = cfg_word;
      A_STAT:  bus_rdata = {29'b0, !busy && !tx_full, !tx_full, rx_full};
      A_CTRL:  bus_rdata = {31'b0, en};
      A_TX:    bus_rdata = txbuf;
      A_RX:    bus_rdata = rxbuf;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpha <= 1'b0; cpol <= 1'b0; dexp <= '0; cs_low <= 1'b0; wl <= '0;
      mode <= '0; dreq_w <= 1'b0; dreq_r <= 1'b0; hold <= 1'b0;
      en <= 1'b0; busy <= 1'b0; armed <= 1'b0; tx_full <= 1'b0; rx_full <= 1'b0;
      smp <= 1'b0; txbuf <= '0; rxbuf <= '0; shreg <= '0; half <= '0; cnt <= '0;
    end else begin
      if (bus_wr && bus_addr == A_CFG) begin
        cpha   <= bus_wdata[0];
        cpol   <= bus_wdata[1];
        dexp   <= bus_wdata[5:2];
        cs_low <= bus_wdata[6];
        wl     <= bus_wdata[11:7];
        mode   <= bus_wdata[13:12];
        dreq_w <= bus_wdata[14];
        dreq_r <= bus_wdata[15];
        hold   <= bus_wdata[20];
      end
      if (bus_wr && bus_addr == A_CTRL) en <= bus_wdata[0];

      if (bus_wr && bus_addr == A_TX) begin
        txbuf   <= bus_wdata;
        tx_full <= 1'b1;
      end else if (load_tx) begin
        tx_full <= 1'b0;
      end

      if (!en) rx_full <= 1'b0;
      else if (word_done && mode != M_TXO) begin
        rx_full <= 1'b1;
        rxbuf   <= rx_word;
      end else if (rd_rx) rx_full <= 1'b0;

      if (!en || !rx_only) armed <= 1'b0;
      else if (load_tx)    armed <= 1'b1;

      if (!en) begin
        busy <= 1'b0;
        half <= '0;
        cnt  <= '0;
      end else if (load_tx || load_cont) begin
        busy  <= 1'b1;
        half  <= '0;
        cnt   <= '0;
        shreg <= load_tx ? txbuf : '0;
      end else if (half_end) begin
        cnt  <= '0;
        half <= half + HW'(1);
        if (!half[0]) smp <= miso;
        else          shreg <= {shreg[DW-2:0], smp};
        if (last_half) busy <= 1'b0;
      end else if (busy) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assert_rxf_at_word_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> ($past(busy) && !busy));
  assert_txonly_no_rxf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> ($past(mode) != M_TXO));
  assert_disable_purge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (!rx_full && !busy));
  assert_txe_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_full) |-> busy);
  assert_idle_sclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> $stable(sclk));
endmodule

// File: tb/test_spi_chan.sv
module test_spi_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic sclk, mosi, cs_out, dma_tx_req, dma_rx_req;
  logic miso = 1'b0;

  always #10 clk = ~clk;

  spi_chan i_spi_chan (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .sclk(sclk), .mosi(mosi), .miso(miso), .cs_out(cs_out),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  int total = 0, bad = 0, ctot = 0, cbad = 0;
  bit m_cpha = 0, m_cpol = 0, m_hold = 0, m_cslow = 0;
  int m_D = 1;

  // per-clock select-line model (R9)
  always @(posedge clk) begin
    #5;
    if (rst_n) begin
      ctot++;
      if (cs_out !== (m_hold ^ m_cslow)) begin
        cbad++;
        $display("FAIL R9 cs_out actual=%b expected=%b", cs_out, m_hold ^ m_cslow);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog R1..all actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total + ctot + 1, bad + cbad + 1);
    $finish;
  end

  function automatic logic [31:0] mk(bit ph, bit po, int e, bit csl, int wlf,
                                     int md, bit dw, bit dr, bit hl);
    logic [31:0] v;
    v = '0;
    v[0] = ph; v[1] = po; v[5:2] = 4'(e); v[6] = csl; v[11:7] = 5'(wlf);
    v[13:12] = 2'(md); v[14] = dw; v[15] = dr; v[20] = hl;
    return v;
  endfunction

  function automatic logic [31:0] wmask(int w);
    if (w >= 32) return 32'hFFFF_FFFF;
    return (32'h1 << w) - 32'h1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a == 5'd0) begin
      m_cpha = d[0]; m_cpol = d[1]; m_D = 1 << d[5:2]; m_cslow = d[6]; m_hold = d[20];
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic slave_run(input logic [31:0] sw, input int w, input int ncyc,
                           output logic [31:0] cap, output int nedges, output int badint);
    logic prev;
    int bi, last;
    cap = '0; nedges = 0; badint = 0; bi = 0; last = 0;
    prev = sclk;
    if (!m_cpha) miso = sw[w-1];
    for (int c = 1; c <= ncyc; c++) begin
      @(negedge clk);
      if (sclk !== prev) begin
        if (nedges > 0 && (c - last) != m_D) badint++;
        last = c;
        nedges++;
        if (sclk !== m_cpol) begin
          if (!m_cpha) cap = {cap[30:0], mosi};
          else begin
            if (bi < w) miso = sw[w-1-bi];
            bi++;
          end
        end else begin
          if (!m_cpha) begin
            bi++;
            if (bi < w) miso = sw[w-1-bi];
          end else cap = {cap[30:0], mosi};
        end
        prev = sclk;
      end
    end
    cap = cap & wmask(w);
  endtask

  task automatic xfer(input logic [31:0] txw, input logic [31:0] sw, input int w, input string req);
    logic [31:0] cap, d;
    int ne, bi;
    wr(5'd12, txw);
    slave_run(sw, w, 2 * w * m_D + 3, cap, ne, bi);
    chk(cap == (txw & wmask(w)), {req, " R3 R5 mosi word"}, cap, txw & wmask(w));
    chk(ne == 2 * w, {req, " R4 edge count"}, ne, 2 * w);
    chk(bi == 0, {req, " R4 half-period"}, bi, 0);
    rd(5'd4, d);
    chk(d == 32'h7, {req, " R11 status after word"}, d, 32'h7);
    rd(5'd16, d);
    chk(d == (sw & wmask(w)), {req, " R5 rx word"}, d, sw & wmask(w));
    rd(5'd4, d);
    chk(d == 32'h6, {req, " R11 rxf cleared by read"}, d, 32'h6);
  endtask

  initial begin
    logic [31:0] d, cap;
    int ne, bi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(5'd4, d);  chk(d == 32'h6, "R2 reset status", d, 32'h6);
    rd(5'd0, d);  chk(d == 32'h0, "R2 reset cfg", d, 32'h0);
    rd(5'd8, d);  chk(d == 32'h0, "R2 reset ctrl", d, 32'h0);
    chk(sclk == 1'b0 && dma_tx_req == 1'b0 && dma_rx_req == 1'b0, "R2 reset pins",
        {sclk, dma_tx_req, dma_rx_req}, 0);

    // R1 configuration readback
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d);  chk(d == 32'h0010_FFFF, "R1 cfg readback", d, 32'h0010_FFFF);
    chk(dma_tx_req == 1'b1, "R12 tx request with enable", dma_tx_req, 1);
    chk(dma_rx_req == 1'b0, "R12 rx request idle", dma_rx_req, 0);

    // R9 select line, channel disabled
    wr(5'd0, mk(0,0,0,1,7,0,0,0,0)); chk(cs_out == 1'b1, "R9 idle active-low", cs_out, 1);
    wr(5'd0, mk(0,0,0,1,7,0,0,0,1)); chk(cs_out == 1'b0, "R9 held active-low", cs_out, 0);
    wr(5'd0, mk(0,0,0,0,7,0,0,0,1)); chk(cs_out == 1'b1, "R9 held active-high", cs_out, 1);
    wr(5'd0, mk(0,0,0,0,7,0,0,0,0)); chk(cs_out == 1'b0, "R9 idle active-high", cs_out, 0);

    // R3 R4 R5 modes, rates and lengths
    wr(5'd8, 32'h1);
    wr(5'd0, mk(0,0,0,1,7,0,0,0,1));  xfer(32'hA5, 32'h3C, 8, "mode0 w8 e0");
    wr(5'd0, mk(1,1,2,1,11,0,0,0,1)); xfer(32'h7ABC, 32'h5A3, 12, "mode3 w12 e2");
    wr(5'd0, mk(1,0,1,1,31,0,0,0,1)); xfer(32'hDEAD_BEEF, 32'h1234_5678, 32, "mode1 w32 e1");
    wr(5'd0, mk(0,1,0,1,3,0,0,0,1));  xfer(32'hF9, 32'hE6, 4, "mode2 w4 e0");
    wr(5'd0, mk(0,0,0,1,0,0,0,0,1));  xfer(32'hA6, 32'hF5, 4, "R5 clamp field0");

    // R6 send only
    wr(5'd0, mk(0,0,0,1,7,2,0,0,1));
    wr(5'd12, 32'h5A);
    slave_run(32'hFF, 8, 19, cap, ne, bi);
    chk(cap == 32'h5A, "R6 tx-only mosi", cap, 32'h5A);
    rd(5'd4, d);  chk(d == 32'h6, "R6 tx-only no rxf", d, 32'h6);

    // R10 R11 queued word and end-of-transfer
    wr(5'd0, mk(0,0,3,1,7,0,0,0,1));
    miso = 1'b1;
    wr(5'd12, 32'h11);
    rd(5'd4, d);  chk(d == 32'h2, "R10 loaded, eot low", d, 32'h2);
    wr(5'd12, 32'h22);
    rd(5'd4, d);  chk(d == 32'h0, "R10 queued, txe low", d, 32'h0);
    repeat (2 * 128 + 20) @(negedge clk);
    rd(5'd4, d);  chk(d == 32'h7, "R11 both words done", d, 32'h7);
    rd(5'd16, d); chk(d == 32'hFF, "R11 second word", d, 32'hFF);

    // R8 purge on disable
    wr(5'd0, mk(0,0,0,1,7,0,0,0,1));
    wr(5'd12, 32'h33);
    repeat (24) @(negedge clk);
    rd(5'd4, d);  chk(d == 32'h7, "R8 word pending", d, 32'h7);
    wr(5'd8, 32'h0);
    rd(5'd4, d);  chk(d == 32'h6, "R8 purge on disable", d, 32'h6);

    // R8 no start when disabled, R12 request lines
    wr(5'd0, mk(0,0,0,1,7,0,1,1,1));
    chk(dma_tx_req == 1'b1 && dma_rx_req == 1'b0, "R12 requests idle", {dma_tx_req, dma_rx_req}, 2'b10);
    wr(5'd12, 32'h44);
    repeat (20) @(negedge clk);
    rd(5'd4, d);  chk(d == 32'h0, "R8 no shift while disabled", d, 32'h0);
    chk(dma_tx_req == 1'b0, "R12 tx request drops", dma_tx_req, 0);
    wr(5'd8, 32'h1);
    slave_run(32'h81, 8, 19, cap, ne, bi);
    chk(cap == 32'h44, "R8 starts on enable", cap, 32'h44);
    chk(dma_tx_req == 1'b1 && dma_rx_req == 1'b1, "R12 both requests", {dma_tx_req, dma_rx_req}, 2'b11);
    rd(5'd16, d); chk(d == 32'h81, "R12 rx word", d, 32'h81);
    chk(dma_rx_req == 1'b0, "R12 rx request cleared", dma_rx_req, 0);

    // R7 receive only
    wr(5'd0, mk(0,0,0,1,7,1,0,0,1));
    wr(5'd12, 32'h0);
    slave_run(32'hC3, 8, 19, cap, ne, bi);
    rd(5'd4, d);  chk(d == 32'h7, "R7 first word status", d, 32'h7);
    rd(5'd16, d); chk(d == 32'hC3, "R7 first word", d, 32'hC3);
    slave_run(32'h96, 8, 19, cap, ne, bi);
    chk(ne == 16, "R7 continues without write", ne, 16);
    rd(5'd16, d); chk(d == 32'h96, "R7 second word", d, 32'h96);
    slave_run(32'h5E, 8, 19, cap, ne, bi);
    slave_run(32'h00, 8, 40, cap, ne, bi);
    chk(ne == 0, "R7 stalls while unread", ne, 0);
    rd(5'd16, d); chk(d == 32'h5E, "R7 third word", d, 32'h5E);
    wr(5'd8, 32'h0);
    rd(5'd4, d);  chk(d == 32'h6, "R8 disable ends receive-only", d, 32'h6);

    $display("test done: total=%0d bad=%0d", total + ctot, bad + cbad);
    $finish;
  end
endmodule